// File: doc/BRIEF.md
# Vector Predicate Mask Builder

This block produces the two 64-bit predicate masks, one for source elements and one for destination elements, that a vector instruction needs before it runs. A requester hands over a predicate mode, a source selector, a destination selector and the vector length over a valid/ready handshake. The block then reads what it needs, one read at a time, and returns both masks over a second valid/ready handshake.

There are three mode values. With no predication, both masks are all ones. In integer mode, each mask comes from one general register. A 3-bit selector picks that register, and the selector can also invert the value or turn it into a one-hot value. In condition mode, each mask is built bit by bit. For element i the block reads one 4-bit condition field, picks one bit of it and may invert that bit.

Both register-file ports answer one clock after their enable. The source mask is always built first and the destination mask second, and both use the same ports.

Top module: `pmask_builder`

## Requirements
- R1: A mode code other than 1 (integer) or 2 (condition) sets both masks to all ones. No register read and no field read happens.
- R2: In integer mode, selector 2 gives register 3, selector 4 gives register 10 and selector 6 gives register 30. The mask is the full 64-bit value of that register.
- R3: In integer mode, selectors 3, 5 and 7 read registers 3, 10 and 30 respectively. The mask is the bitwise complement of the value read.
- R4: In integer mode, selector 1 reads register 3. The mask is a single one at the bit position given by bits [5:0] of that register.
- R5: In integer mode, selector 0 gives an all-ones mask and issues no read for that mask.
- R6: In condition mode, code c selects bit c[2:1] of the field read, and c[0] inverts it. So 0/1 use bit 0, 2/3 use bit 1, 4/5 use bit 2 and 6/7 use bit 3. Mask bit i equals c[0] XOR the selected bit of the field read for element i.
- R7: The field read for element i drives an 8-bit one-hot enable. Its set bit is at position 7 - ((i + FIELD_BASE) mod 8). Elements are read in order from 0 to VL-1.
- R8: In condition mode, mask bits at positions VL and above are zero. A VL of 0 issues no field reads and gives two all-zero masks. A VL above 64 is treated as 64.
- R9: Read data is taken in the cycle after the enable. All source-mask reads come before all destination-mask reads. Each enable lasts exactly one cycle and is followed by a cycle with no read.
- R10: `req_ready` is high only while the block is idle. Once `mask_valid` rises, it and both masks hold steady until `mask_ready` is seen high. The block is then idle again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_mode | input | 2 | 0 none, 1 integer, 2 condition, 3 none |
| req_src_sel | input | 3 | Source predicate selector |
| req_dst_sel | input | 3 | Destination predicate selector |
| req_vl | input | VL_W (7) | Vector length |
| ireg_ren | output | 1 | Integer register read enable |
| ireg_addr | output | RADDR_W (5) | Integer register number |
| ireg_rdata | input | MASK_W (64) | Register data, one cycle after enable |
| cfield_ren | output | NUM_FIELDS (8) | One-hot condition field read enable |
| cfield_rdata | input | 4 | Field data, one cycle after enable |
| mask_valid | output | 1 | Masks ready |
| mask_ready | input | 1 | Consumer takes the masks |
| src_mask | output | MASK_W (64) | Source predicate mask |
| dst_mask | output | MASK_W (64) | Destination predicate mask |

## Verification
The hardest case to reach is a full-length condition loop in which the field index wraps around the 8 fields while the base offset is non-zero. The bench reaches it with a non-zero FIELD_BASE and vector lengths of 13, 64 and 70, and it logs every enable the block issues. Each run also loads a different field pattern, so a wrong bit, a wrong invert or a wrong element order shows up in the mask. The integer sweep covers every pair of source and destination selectors under two values of register 3, one of which has a shift amount of 63.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

   typedef enum logic [1:0] {
      PM_NONE = 2'd0,
      PM_INT  = 2'd1,
      PM_COND = 2'd2,
      PM_RSVD = 2'd3
   } pm_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_CAPT  = 2'd2,
      ST_DONE  = 2'd3
   } pm_state_e;

   localparam int SEL_W   = 3;
   localparam int FIELD_W = 4;

endpackage

// File: rtl/pmask_int_decode.sv
module pmask_int_decode #(
   parameter int RADDR_W = 5,
   parameter int REG_A   = 3,
   parameter int REG_B   = 10,
   parameter int REG_C   = 30
) (
   input  logic [2:0]         sel,
   output logic [RADDR_W-1:0] addr,
   output logic               invert,
   output logic               unary,
   output logic               bypass
);
   always_comb begin
      addr   = RADDR_W'(REG_A);
      invert = 1'b0;
      unary  = 1'b0;
      bypass = 1'b0;
      case (sel)
         3'd0: bypass = 1'b1;
         3'd1: unary  = 1'b1;
         3'd2: ;
         3'd3: invert = 1'b1;
         3'd4: addr = RADDR_W'(REG_B);
         3'd5: begin addr = RADDR_W'(REG_B); invert = 1'b1; end
         3'd6: addr = RADDR_W'(REG_C);
         default: begin addr = RADDR_W'(REG_C); invert = 1'b1; end
      endcase
   end
endmodule

// File: rtl/pmask_int_shape.sv
module pmask_int_shape #(
   parameter int MASK_W = 64
) (
   input  logic [MASK_W-1:0] value,
   input  logic              invert,
   input  logic              unary,
   output logic [MASK_W-1:0] mask
);
   localparam int SH_W = $clog2(MASK_W);

   always_comb begin
      if (unary)
         mask = MASK_W'(1) << value[SH_W-1:0];
      else if (invert)
         mask = ~value;
      else
         mask = value;
   end
endmodule

// File: rtl/pmask_cond_pick.sv
module pmask_cond_pick (
   input  logic [2:0] code,
   input  logic [3:0] field,
   output logic       bit_out
);
   logic [1:0] idx;
   always_comb begin
      idx     = code[2:1];
      bit_out = field[idx] ^ code[0];
   end
endmodule

// File: rtl/pmask_field_sel.sv
module pmask_field_sel #(
   parameter int NUM_FIELDS = 8,
   parameter int IDX_W      = 7,
   parameter int FIELD_BASE = 0
) (
   input  logic [IDX_W-1:0]      idx,
   output logic [NUM_FIELDS-1:0] en
);
   localparam int FW = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

   logic [FW-1:0] slot;
   always_comb slot = FW'((int'(idx) + FIELD_BASE) % NUM_FIELDS);

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      assign en[f] = (slot == FW'(NUM_FIELDS - 1 - f));
   end
endmodule

// File: rtl/pmask_builder.sv
module pmask_builder
   import pmask_pkg::*;
#(
   parameter int MASK_W     = 64,
   parameter int VL_W       = 7,
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_BASE = 0,
   parameter int RADDR_W    = 5,
   parameter int REG_A      = 3,
   parameter int REG_B      = 10,
   parameter int REG_C      = 30
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [1:0]            req_mode,
   input  logic [2:0]            req_src_sel,
   input  logic [2:0]            req_dst_sel,
   input  logic [VL_W-1:0]       req_vl,
   output logic                  ireg_ren,
   output logic [RADDR_W-1:0]    ireg_addr,
   input  logic [MASK_W-1:0]     ireg_rdata,
   output logic [NUM_FIELDS-1:0] cfield_ren,
   input  logic [3:0]            cfield_rdata,
   output logic                  mask_valid,
   input  logic                  mask_ready,
   output logic [MASK_W-1:0]     src_mask,
   output logic [MASK_W-1:0]     dst_mask
);
   localparam int ELEM_W = $clog2(MASK_W + 1);
   localparam int SH_W   = $clog2(MASK_W);

   initial begin
      assert (MASK_W >= 2 && (MASK_W & (MASK_W - 1)) == 0)
         else $error("MASK_W must be a power of two");
      assert (NUM_FIELDS >= 2) else $error("NUM_FIELDS too small");
      assert (FIELD_BASE >= 0) else $error("FIELD_BASE negative");
      assert (REG_A < (1 << RADDR_W) && REG_B < (1 << RADDR_W) && REG_C < (1 << RADDR_W))
         else $error("register number exceeds address width");
   end

   pm_state_e         state_q;
   pm_mode_e          mode_q;
   logic              phase_q;
   logic [2:0]        src_sel_q, dst_sel_q;
   logic [ELEM_W-1:0] vl_q, elem_q;
   logic [MASK_W-1:0] src_q, dst_q;

   logic [2:0]        cur_sel;
   logic [MASK_W-1:0] cur_mask, int_mask, cond_mask;
   logic [RADDR_W-1:0] int_addr;
   logic              int_inv, int_unary, int_bypass;
   logic              cond_bit, loop_end, is_int, is_cond;
   logic [NUM_FIELDS-1:0] field_en;
   logic [ELEM_W-1:0] vl_clamped;

   always_comb begin
      cur_sel  = phase_q ? dst_sel_q : src_sel_q;
      cur_mask = phase_q ? dst_q : src_q;
      is_int   = (mode_q == PM_INT);
      is_cond  = (mode_q == PM_COND);
      loop_end = (elem_q == vl_q);
      vl_clamped = (int'(req_vl) > MASK_W) ? ELEM_W'(MASK_W) : ELEM_W'(req_vl);
   end

   pmask_int_decode #(
      .RADDR_W(RADDR_W), .REG_A(REG_A), .REG_B(REG_B), .REG_C(REG_C)
   ) u_idec (
      .sel(cur_sel), .addr(int_addr), .invert(int_inv),
      .unary(int_unary), .bypass(int_bypass)
   );

   pmask_int_shape #(.MASK_W(MASK_W)) u_ishape (
      .value(ireg_rdata), .invert(int_inv), .unary(int_unary), .mask(int_mask)
   );

   pmask_cond_pick u_cpick (
      .code(cur_sel), .field(cfield_rdata), .bit_out(cond_bit)
   );

   pmask_field_sel #(
      .NUM_FIELDS(NUM_FIELDS), .IDX_W(ELEM_W), .FIELD_BASE(FIELD_BASE)
   ) u_fsel (
      .idx(elem_q), .en(field_en)
   );

   always_comb cond_mask = cur_mask | (MASK_W'(cond_bit) << elem_q[SH_W-1:0]);

   always_comb begin
      req_ready  = (state_q == ST_IDLE);
      mask_valid = (state_q == ST_DONE);
      ireg_ren   = (state_q == ST_ISSUE) && is_int && !int_bypass;
      ireg_addr  = int_addr;
      cfield_ren = ((state_q == ST_ISSUE) && is_cond && !loop_end) ? field_en : '0;
      src_mask   = src_q;
      dst_mask   = dst_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_q    <= PM_NONE;
         phase_q   <= 1'b0;
         src_sel_q <= '0;
         dst_sel_q <= '0;
         vl_q      <= '0;
         elem_q    <= '0;
         src_q     <= '0;
         dst_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               mode_q    <= pm_mode_e'(req_mode);
               src_sel_q <= req_src_sel;
               dst_sel_q <= req_dst_sel;
               vl_q      <= vl_clamped;
               phase_q   <= 1'b0;
               elem_q    <= '0;
               if (req_mode == PM_INT || req_mode == PM_COND) begin
                  src_q   <= '0;
                  dst_q   <= '0;
                  state_q <= ST_ISSUE;
               end else begin
                  src_q   <= '1;
                  dst_q   <= '1;
                  state_q <= ST_DONE;
               end
            end
            ST_ISSUE: begin
               if ((is_int && int_bypass) || (!is_int && loop_end)) begin
                  if (is_int) begin
                     if (phase_q) dst_q <= '1;
                     else         src_q <= '1;
                  end
                  if (phase_q) state_q <= ST_DONE;
                  else begin
                     phase_q <= 1'b1;
                     elem_q  <= '0;
                  end
               end else begin
                  state_q <= ST_CAPT;
               end
            end
            ST_CAPT: begin
               if (is_int) begin
                  if (phase_q) dst_q <= int_mask;
                  else         src_q <= int_mask;
                  if (phase_q) state_q <= ST_DONE;
                  else begin
                     phase_q <= 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end else begin
                  if (phase_q) dst_q <= cond_mask;
                  else         src_q <= cond_mask;
                  elem_q  <= elem_q + 1'b1;
                  state_q <= ST_ISSUE;
               end
            end
            default: if (mask_ready) state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   logic [MASK_W-1:0] vl_span;
   always_comb begin
      vl_span = '1;
      if (int'(vl_q) < MASK_W) vl_span = (MASK_W'(1) << vl_q[SH_W-1:0]) - MASK_W'(1);
   end

   a_r1_none_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid && !is_int && !is_cond |-> (&src_mask) && (&dst_mask));

   a_r7_field_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cfield_ren) && !(ireg_ren && (|cfield_ren)));

   a_r8_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid && is_cond |-> ((src_mask & ~vl_span) == '0) && ((dst_mask & ~vl_span) == '0));

   a_r9_ireg_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ireg_ren |=> !ireg_ren && (cfield_ren == '0));

   a_r9_field_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (|cfield_ren) |=> (cfield_ren == '0) && !ireg_ren);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid && !mask_ready |=> mask_valid && $stable(src_mask) && $stable(dst_mask));

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   a_r10_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid && mask_ready |=> req_ready && !mask_valid);

endmodule

// File: tb/pmask_builder_test.sv
module pmask_builder_test;
   localparam int CLK_PERIOD = 10;
   localparam int MW   = 64;
   localparam int VW   = 7;
   localparam int NF   = 8;
   localparam int BASE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, mask_ready = 1'b0;
   logic req_ready, mask_valid, ireg_ren;
   logic [1:0] req_mode = '0;
   logic [2:0] req_src_sel = '0, req_dst_sel = '0;
   logic [VW-1:0] req_vl = '0;
   logic [4:0] ireg_addr;
   logic [MW-1:0] ireg_rdata = '0;
   logic [NF-1:0] cfield_ren;
   logic [3:0] cfield_rdata = '0;
   logic [MW-1:0] src_mask, dst_mask;

   int checks = 0;
   int errors = 0;

   logic [MW-1:0] ireg_mem [32];
   logic [3:0]    cf_mem [NF];
   logic [4:0]    ird_log [8];
   logic [NF-1:0] cf_log [300];
   int ird_n = 0;
   int cf_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmask_builder #(
      .MASK_W(MW), .VL_W(VW), .NUM_FIELDS(NF), .FIELD_BASE(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_src_sel(req_src_sel), .req_dst_sel(req_dst_sel),
      .req_vl(req_vl), .ireg_ren(ireg_ren), .ireg_addr(ireg_addr),
      .ireg_rdata(ireg_rdata), .cfield_ren(cfield_ren), .cfield_rdata(cfield_rdata),
      .mask_valid(mask_valid), .mask_ready(mask_ready),
      .src_mask(src_mask), .dst_mask(dst_mask)
   );

   // register-file models: data one clock after the enable
   always @(posedge clk) begin
      if (ireg_ren) begin
         ireg_rdata <= ireg_mem[ireg_addr];
         if (ird_n < 8) ird_log[ird_n] = ireg_addr;
         ird_n = ird_n + 1;
      end
      if (|cfield_ren) begin
         for (int f = 0; f < NF; f++)
            if (cfield_ren[f]) cfield_rdata <= cf_mem[f];
         if (cf_n < 300) cf_log[cf_n] = cfield_ren;
         cf_n = cf_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] sel_reg(input logic [2:0] c);
      case (c[2:1])
         2'd2: return 5'd10;
         2'd3: return 5'd30;
         default: return 5'd3;
      endcase
   endfunction

   function automatic logic [MW-1:0] exp_int(input logic [2:0] c);
      logic [MW-1:0] v;
      v = ireg_mem[sel_reg(c)];
      if (c == 3'd0) return '1;
      if (c == 3'd1) return 64'd1 << ireg_mem[3][5:0];
      if (c[0]) return ~v;
      return v;
   endfunction

   function automatic string int_tag(input logic [2:0] c);
      if (c == 3'd0) return "R5";
      if (c == 3'd1) return "R4";
      if (c[0]) return "R3";
      return "R2";
   endfunction

   function automatic int field_pos(input int i);
      return NF - 1 - ((i + BASE) % NF);
   endfunction

   function automatic logic [MW-1:0] exp_cond(input logic [2:0] c, input int n);
      logic [MW-1:0] m;
      m = '0;
      for (int i = 0; i < n; i++)
         m[i] = cf_mem[field_pos(i)][c[2:1]] ^ c[0];
      return m;
   endfunction

   task automatic run(input logic [1:0] mode, input logic [2:0] s, input logic [2:0] d, input int vl);
      int n, wait_cyc, bad, exp_reads;
      logic [MW-1:0] es, ed, hs, hd;
      @(negedge clk);
      ird_n = 0;
      cf_n  = 0;
      req_mode = mode; req_src_sel = s; req_dst_sel = d; req_vl = VW'(vl);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_cyc = 0;
      while (!mask_valid && wait_cyc < 1000) begin
         @(negedge clk);
         wait_cyc++;
      end
      chk(mask_valid, "R10 mask_valid arrives", 64'(mask_valid), 64'd1);
      n = (vl > MW) ? MW : vl;
      if (mode == 2'd1) begin
         es = exp_int(s); ed = exp_int(d);
         chk(src_mask == es, int_tag(s), src_mask, es);
         chk(dst_mask == ed, int_tag(d), dst_mask, ed);
         exp_reads = (s != 0 ? 1 : 0) + (d != 0 ? 1 : 0);
         chk(ird_n == exp_reads && cf_n == 0, (s == 0 || d == 0) ? "R5 read count" : "R9 read count",
             64'(ird_n), 64'(exp_reads));
         if (s != 0 && d != 0)
            chk(ird_log[0] == sel_reg(s) && ird_log[1] == sel_reg(d), "R9 source before destination",
                {ird_log[0], ird_log[1]}, {sel_reg(s), sel_reg(d)});
      end else if (mode == 2'd2) begin
         es = exp_cond(s, n); ed = exp_cond(d, n);
         chk(src_mask == es, "R6 R8 source mask", src_mask, es);
         chk(dst_mask == ed, "R6 R8 destination mask", dst_mask, ed);
         chk(cf_n == 2 * n && ird_n == 0, "R8 field read count", 64'(cf_n), 64'(2 * n));
         bad = 0;
         for (int k = 0; k < 2 * n && k < 300; k++)
            if (cf_log[k] != (NF'(1) << field_pos(k % n))) bad++;
         chk(bad == 0, "R7 enable sequence", 64'(bad), 64'd0);
      end else begin
         chk((&src_mask) && (&dst_mask), "R1 all ones", src_mask & dst_mask, '1);
         chk(ird_n == 0 && cf_n == 0, "R1 no reads", 64'(ird_n + cf_n), 64'd0);
      end
      hs = src_mask; hd = dst_mask;
      @(negedge clk);
      @(negedge clk);
      chk(mask_valid && !req_ready && src_mask == hs && dst_mask == hd, "R10 hold",
          {62'd0, mask_valid, req_ready}, 64'd2);
      mask_ready = 1'b1;
      @(negedge clk);
      mask_ready = 1'b0;
      chk(!mask_valid && req_ready, "R10 back to idle", {62'd0, mask_valid, req_ready}, 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 32; k++)
         ireg_mem[k] = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ 64'(k << 8);
      for (int f = 0; f < NF; f++) cf_mem[f] = 4'(f * 5 + 3);
      repeat (3) @(negedge clk);
      chk(req_ready && !mask_valid && !ireg_ren && cfield_ren == '0, "R10 reset state",
          {61'd0, req_ready, mask_valid, ireg_ren}, 64'd4);
      rst_n = 1'b1;

      run(2'd0, 3'd2, 3'd5, 5);
      run(2'd3, 3'd7, 3'd1, 0);

      for (int r = 0; r < 2; r++) begin
         ireg_mem[3] = (r == 0) ? 64'hF0F0_0000_0000_0025 : 64'h1234_5678_9ABC_DEFF;
         for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
               run(2'd1, 3'(s), 3'(d), 9);
      end

      for (int c = 0; c < 8; c++) begin
         foreach (cf_mem[f]) cf_mem[f] = 4'(f * 7 + c * 3 + 1);
         run(2'd2, 3'(c), 3'((c + 3) % 8), 0);
         run(2'd2, 3'(c), 3'((c + 5) % 8), 1);
         run(2'd2, 3'(c), 3'((c + 1) % 8), 3);
         run(2'd2, 3'(c), 3'((c + 2) % 8), 13);
         run(2'd2, 3'(c), 3'((c + 7) % 8), 64);
         run(2'd2, 3'(c), 3'((c + 4) % 8), 70);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule